// File: doc/BRIEF.md
# Palette Entry Converter

This block turns raw palette words, streamed in from a fetch engine, into one uniform internal colour entry and writes each entry into an on-chip palette RAM. Every stored entry carries an 8-bit red, green and blue component and a transparency flag. The raw layout is chosen by a 2-bit format selector. Three of the layouts are 32-bit words with a transparency bit. The fourth is a packed 16-bit layout in which one input word carries two entries. A monochrome switch replaces all three colour components with the low byte of the raw entry.

A load starts with a one-cycle start pulse. The block samples the pixel depth, format and monochrome setting at that pulse. The depth sets how many entries are converted, and a depth with no palette ignores the pulse. The block then takes words over a valid/ready handshake, writes one entry per accepted raw entry, and pulses a completion flag with the last write. It reports the byte offset of the entry being converted. It also raises a request flag whenever the format selector no longer matches the format used by the most recent load, so that a frame controller can schedule a reload.

Top module: `pal_loader`

## Requirements
- R1: While reset is held, and until the first load begins, `busy`, `in_ready`, `wr_en` and `done` are low.
- R2: `cfg_depth` code 0 loads 4 entries, code 1 loads 16 and code 2 loads 256. Entries are written to addresses 0 up to count-1 in order. `done` is high together with the write to address count-1, and `busy` is high from the cycle after the accepted start until that write.
- R3: A start pulse with `cfg_depth` code 3 is ignored. No write happens, `busy` stays low, and the format remembered for `reconv_req` is unchanged.
- R4: Format 0 takes two entries per input word, bits 15:0 first and then bits 31:16. Within a halfword, red = bits 15:11, green = bits 10:5 and blue = bits 4:0, each placed in the upper bits of its 8-bit component. The transparency flag is 0.
- R5: In format 1, red = bits 23:19, green = bits 15:10, blue = bits 7:3 (upper-aligned) and transparency = bit 24.
- R6: In format 2, red = bits 23:18, green = bits 15:10, blue = bits 7:2 (upper-aligned) and transparency = bit 24.
- R7: In format 3, red = bits 23:16, green = bits 15:8, blue = bits 7:0 and transparency = bit 24.
- R8: With monochrome set, red, green and blue all equal bits 7:0 of the raw entry (of the halfword in format 0). Transparency still follows the format.
- R9: While `busy`, `rd_byte_off` equals the index of the next entry times 2 in format 0, and times 4 in the other formats.
- R10: `reconv_req` is low until the first accepted load. After that it is high exactly when `cfg_fmt` differs from the format sampled by the most recent accepted start.
- R11: A write occurs in the cycle after an accepted raw entry, that is `busy` and `in_valid` at a clock edge, and at no other time. `in_ready` is high only while `busy`. In format 0 it is high only for the upper halfword.
- R12: Changes to `cfg_fmt`, `cfg_mono` or `cfg_depth` during a load, and start pulses while `busy`, have no effect on that load.
- Stored entry layout `wr_data`: bit 24 transparency, bits 23:16 red, 15:8 green, 7:0 blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | One-cycle request to begin a palette load |
| cfg_depth | input | 2 | Pixel depth code: 0 = 2 bpp, 1 = 4 bpp, 2 = 8 bpp, 3 = no palette |
| cfg_fmt | input | 2 | Raw palette format selector |
| cfg_mono | input | 1 | Monochrome override |
| in_data | input | 32 | Raw palette word |
| in_valid | input | 1 | Raw word valid |
| in_ready | output | 1 | Raw word consumed at this edge |
| busy | output | 1 | Load in progress |
| rd_byte_off | output | PAL_AW+2 | Byte offset of the entry being converted |
| wr_en | output | 1 | Palette RAM write strobe |
| wr_addr | output | PAL_AW | Palette RAM write address |
| wr_data | output | 3*CH_W+1 | Converted entry |
| done | output | 1 | Last entry of the load written |
| reconv_req | output | 1 | Format selector differs from the last loaded format |

## Verification
On every cycle the assertions check the handshake and ordering rules: `in_ready` only while busy, every write one cycle after an accepted entry, addresses that step by one, `done` only together with a final write, a busy period that begins only after a start pulse, and an aligned byte offset. The colour decoding of each format, the monochrome override, the entry counts per depth, the ignored start at an unsupported depth and the latching of the configuration can only be shown by the bench's scenarios. There, a behavioural model predicts every stored entry from the raw words it sends.

// File: rtl/pal_pkg.sv
package pal_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      DEPTH_2B   = 2'd0,
      DEPTH_4B   = 2'd1,
      DEPTH_8B   = 2'd2,
      DEPTH_NONE = 2'd3
   } pal_depth_e;

   typedef enum logic [1:0] {
      FMT_565H = 2'd0,
      FMT_565T = 2'd1,
      FMT_666T = 2'd2,
      FMT_888T = 2'd3
   } pal_fmt_e;

endpackage

// File: rtl/pal_count_decode.sv
module pal_count_decode
   import pal_pkg::*;
#(
   parameter int PAL_AW = 8
) (
   input  pal_depth_e          depth,
   output logic                has_pal,
   output logic [PAL_AW-1:0]   last_idx
);
   localparam int N_DEPTH = 3;

   logic [PAL_AW-1:0] last_tab [N_DEPTH];

   // entry count is 2**bpp, with bpp = 2, 4, 8
   for (genvar g = 0; g < N_DEPTH; g++) begin : g_tab
      localparam int BPP = 2 << g;
      assign last_tab[g] = PAL_AW'((1 << BPP) - 1);
   end

   always_comb begin
      has_pal  = 1'b1;
      last_idx = '0;
      case (depth)
         DEPTH_2B: last_idx = last_tab[0];
         DEPTH_4B: last_idx = last_tab[1];
         DEPTH_8B: last_idx = last_tab[2];
         default:  has_pal  = 1'b0;
      endcase
   end

endmodule

// File: rtl/pal_fmt_convert.sv
module pal_fmt_convert
   import pal_pkg::*;
#(
   parameter int CH_W = 8,
   localparam int ENT_W = 3*CH_W + 1
) (
   input  logic [WORD_W-1:0] word,
   input  logic              half,
   input  pal_fmt_e          fmt,
   input  logic              mono,
   output logic [ENT_W-1:0]  entry
);
   logic [15:0]      hw;
   logic [7:0]       grey8;
   logic [ENT_W-1:0] lane [4];

   function automatic logic [CH_W-1:0] widen(input logic [7:0] v);
      logic [CH_W+7:0] tmp;
      tmp = {v, {CH_W{1'b0}}} >> 8;
      return tmp[CH_W-1:0];
   endfunction

   assign hw = half ? word[31:16] : word[15:0];

   for (genvar f = 0; f < 4; f++) begin : g_lane
      logic [7:0] r8, g8, b8;
      logic       t;
      if (f == 0) begin : g_h565
         assign r8 = {hw[15:11], 3'b000};
         assign g8 = {hw[10:5],  2'b00};
         assign b8 = {hw[4:0],   3'b000};
         assign t  = 1'b0;
      end else if (f == 1) begin : g_w565
         assign r8 = {word[23:19], 3'b000};
         assign g8 = {word[15:10], 2'b00};
         assign b8 = {word[7:3],   3'b000};
         assign t  = word[24];
      end else if (f == 2) begin : g_w666
         assign r8 = {word[23:18], 2'b00};
         assign g8 = {word[15:10], 2'b00};
         assign b8 = {word[7:2],   2'b00};
         assign t  = word[24];
      end else begin : g_w888
         assign r8 = word[23:16];
         assign g8 = word[15:8];
         assign b8 = word[7:0];
         assign t  = word[24];
      end
      assign lane[f] = {t, widen(r8), widen(g8), widen(b8)};
   end

   assign grey8 = (fmt == FMT_565H) ? hw[7:0] : word[7:0];

   always_comb begin
      entry = lane[fmt];
      if (mono) begin
         entry = {lane[fmt][ENT_W-1], widen(grey8), widen(grey8), widen(grey8)};
      end
   end

endmodule

// File: rtl/pal_load_ctrl.sv
module pal_load_ctrl
   import pal_pkg::*;
#(
   parameter int PAL_AW = 8,
   localparam int OFF_W = PAL_AW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_start,
   input  logic              has_pal,
   input  logic [PAL_AW-1:0] last_idx,
   input  pal_fmt_e          cfg_fmt,
   input  logic              cfg_mono,
   input  logic              in_valid,
   output logic              busy,
   output logic [PAL_AW-1:0] idx,
   output logic              half,
   output pal_fmt_e          fmt_l,
   output logic              mono_l,
   output logic              take,
   output logic              last_take,
   output logic              in_ready,
   output logic              reconv_req,
   output logic [OFF_W-1:0]  byte_off
);
   logic [PAL_AW-1:0] last_l;
   logic              seen;
   logic              accept;

   assign accept    = !busy && load_start && has_pal;
   assign take      = busy && in_valid;
   assign last_take = take && (idx == last_l);
   assign in_ready  = busy && ((fmt_l != FMT_565H) || half);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         half   <= 1'b0;
         fmt_l  <= FMT_565H;
         mono_l <= 1'b0;
         last_l <= '0;
         seen   <= 1'b0;
      end else if (accept) begin
         busy   <= 1'b1;
         idx    <= '0;
         half   <= 1'b0;
         fmt_l  <= cfg_fmt;
         mono_l <= cfg_mono;
         last_l <= last_idx;
         seen   <= 1'b1;
      end else if (take) begin
         idx <= idx + 1'b1;
         if (fmt_l == FMT_565H) begin
            half <= !half;
         end
         if (idx == last_l) begin
            busy <= 1'b0;
         end
      end
   end

   assign reconv_req = seen && (cfg_fmt != fmt_l);
   assign byte_off   = (fmt_l == FMT_565H) ? {1'b0, idx, 1'b0} : {idx, 2'b00};

endmodule

// File: rtl/pal_loader.sv
module pal_loader
   import pal_pkg::*;
#(
   parameter int PAL_AW = 8,
   parameter int CH_W   = 8,
   localparam int OFF_W = PAL_AW + 2,
   localparam int ENT_W = 3*CH_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_start,
   input  logic [1:0]        cfg_depth,
   input  logic [1:0]        cfg_fmt,
   input  logic              cfg_mono,
   input  logic [31:0]       in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              busy,
   output logic [OFF_W-1:0]  rd_byte_off,
   output logic              wr_en,
   output logic [PAL_AW-1:0] wr_addr,
   output logic [ENT_W-1:0]  wr_data,
   output logic              done,
   output logic              reconv_req
);
   if (PAL_AW < 8) begin : g_chk_aw
      $error("pal_loader: PAL_AW must hold 256 entries");
   end
   if (CH_W < 8) begin : g_chk_ch
      $error("pal_loader: CH_W must be at least 8");
   end

   logic              has_pal;
   logic [PAL_AW-1:0] last_idx;
   logic [PAL_AW-1:0] idx;
   logic              half;
   pal_fmt_e          fmt_l;
   logic              mono_l;
   logic              take;
   logic              last_take;
   logic [ENT_W-1:0]  conv_entry;

   pal_count_decode #(.PAL_AW(PAL_AW)) u_count (
      .depth    (pal_depth_e'(cfg_depth)),
      .has_pal  (has_pal),
      .last_idx (last_idx)
   );

   pal_load_ctrl #(.PAL_AW(PAL_AW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_start (load_start),
      .has_pal    (has_pal),
      .last_idx   (last_idx),
      .cfg_fmt    (pal_fmt_e'(cfg_fmt)),
      .cfg_mono   (cfg_mono),
      .in_valid   (in_valid),
      .busy       (busy),
      .idx        (idx),
      .half       (half),
      .fmt_l      (fmt_l),
      .mono_l     (mono_l),
      .take       (take),
      .last_take  (last_take),
      .in_ready   (in_ready),
      .reconv_req (reconv_req),
      .byte_off   (rd_byte_off)
   );

   pal_fmt_convert #(.CH_W(CH_W)) u_conv (
      .word  (in_data),
      .half  (half),
      .fmt   (fmt_l),
      .mono  (mono_l),
      .entry (conv_entry)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         done    <= 1'b0;
      end else begin
         wr_en <= take;
         done  <= last_take;
         if (take) begin
            wr_addr <= idx;
            wr_data <= conv_entry;
         end
      end
   end

endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk #(
   parameter int PAL_AW = 8,
   localparam int OFF_W = PAL_AW + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_start,
   input logic              in_valid,
   input logic              in_ready,
   input logic              busy,
   input logic [OFF_W-1:0]  rd_byte_off,
   input logic              wr_en,
   input logic [PAL_AW-1:0] wr_addr,
   input logic              done
);
   logic [PAL_AW-1:0] prev_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_addr <= '0;
      end else if (wr_en) begin
         prev_addr <= wr_addr;
      end
   end

   a_r11_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   a_r11_write_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(busy && in_valid));

   a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0) |-> (wr_addr == prev_addr + 1'b1));

   a_r2_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_en && !busy));

   a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(load_start));

   a_r9_offset_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_byte_off[0]);

endmodule

bind pal_loader pal_loader_chk #(.PAL_AW(PAL_AW)) u_pal_loader_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load_start  (load_start),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .busy        (busy),
   .rd_byte_off (rd_byte_off),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .done        (done)
);

// File: tb/pal_loader_bench.sv
module pal_loader_bench;
   localparam int PAL_AW = 8;
   localparam int OFF_W  = PAL_AW + 2;
   localparam int ENT_W  = 25;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_start = 1'b0;
   logic [1:0]        cfg_depth = 2'd0;
   logic [1:0]        cfg_fmt = 2'd0;
   logic              cfg_mono = 1'b0;
   logic [31:0]       in_data = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic              busy;
   logic [OFF_W-1:0]  rd_byte_off;
   logic              wr_en;
   logic [PAL_AW-1:0] wr_addr;
   logic [ENT_W-1:0]  wr_data;
   logic              done;
   logic              reconv_req;

   always #10 clk = ~clk;

   pal_loader u_pal_loader (
      .clk(clk), .rst_n(rst_n), .load_start(load_start), .cfg_depth(cfg_depth),
      .cfg_fmt(cfg_fmt), .cfg_mono(cfg_mono), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .busy(busy), .rd_byte_off(rd_byte_off), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .reconv_req(reconv_req)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   int          addr_q[$];
   bit [24:0]   data_q[$];
   int          wr_cnt = 0;
   int          exp_stride = 4;
   int          exp_fmt = 0;
   int          exp_last = 0;
   bit          done_seen = 0;
   bit          mon_on = 0;
   string       cur_req = "R7";
   bit [31:0]   lcg = 32'h1234_5678;
   int          cyc = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic bit [24:0] exp_ent(int fmt, bit mono, bit [31:0] w, bit hi);
      bit [15:0] h;
      int r, g, b, t, lowb;
      h = hi ? w[31:16] : w[15:0];
      lowb = w & 255;
      t = (w >> 24) & 1;
      case (fmt)
         0: begin
            r = (h >> 11) * 8; g = ((h >> 5) & 63) * 4; b = (h & 31) * 8;
            t = 0; lowb = h & 255;
         end
         1: begin
            r = ((w >> 19) & 31) * 8; g = ((w >> 10) & 63) * 4; b = ((w >> 3) & 31) * 8;
         end
         2: begin
            r = ((w >> 18) & 63) * 4; g = ((w >> 10) & 63) * 4; b = ((w >> 2) & 63) * 4;
         end
         default: begin
            r = (w >> 16) & 255; g = (w >> 8) & 255; b = w & 255;
         end
      endcase
      if (mono) begin
         r = lowb; g = lowb; b = lowb;
      end
      return 25'((t << 24) | (r << 16) | (g << 8) | b);
   endfunction

   // per-clock comparison with the behavioural model
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (wr_en) begin
            if (addr_q.size() == 0) begin
               chk(1'b0, "R11 unexpected write", wr_addr, 0);
            end else begin
               chk(wr_addr == addr_q[0], "R2 write address", wr_addr, addr_q[0]);
               chk(wr_data == data_q[0], cur_req, wr_data, data_q[0]);
               void'(addr_q.pop_front());
               void'(data_q.pop_front());
            end
            wr_cnt++;
         end
         if (done) begin
            chk(wr_en && wr_addr == exp_last, "R2 done on last entry", wr_addr, exp_last);
            done_seen = 1;
         end
         if (busy) begin
            chk(rd_byte_off == wr_cnt * exp_stride, "R9 byte offset", rd_byte_off, wr_cnt * exp_stride);
            if (exp_fmt == 0)
               chk(in_ready == wr_cnt[0], "R11 ready on upper half", in_ready, wr_cnt[0]);
            else
               chk(in_ready == 1'b1, "R11 ready per word", in_ready, 1);
         end else begin
            chk(in_ready == 1'b0, "R11 ready while idle", in_ready, 0);
         end
      end
   end

   task automatic do_load(input int dep, input int fmt, input bit mono, input int gap,
                          input bit midchg, input string req);
      int n, nw, k;
      bit [31:0] words[$];
      bit r;
      n  = 4 << (2 * dep);
      if (dep == 2) n = 256;
      nw = (fmt == 0) ? n / 2 : n;
      for (int i = 0; i < nw; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         words.push_back(lcg ^ (lcg >> 7));
      end
      for (int i = 0; i < nw; i++) begin
         if (fmt == 0) begin
            addr_q.push_back(2*i);     data_q.push_back(exp_ent(fmt, mono, words[i], 0));
            addr_q.push_back(2*i + 1); data_q.push_back(exp_ent(fmt, mono, words[i], 1));
         end else begin
            addr_q.push_back(i);       data_q.push_back(exp_ent(fmt, mono, words[i], 0));
         end
      end
      cur_req = req;
      exp_fmt = fmt;
      exp_stride = (fmt == 0) ? 2 : 4;
      exp_last = n - 1;
      wr_cnt = 0;
      done_seen = 0;
      cfg_depth = 2'(dep);
      cfg_fmt = 2'(fmt);
      cfg_mono = mono;
      load_start = 1'b1;
      @(negedge clk);
      load_start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      k = 0;
      while (k < nw) begin
         if (gap > 0 && (k % gap) == gap - 1 && !in_valid) begin
            @(negedge clk);
         end
         if (midchg && k == 1) begin
            cfg_fmt = 2'(fmt ^ 1);
            cfg_mono = ~mono;
            cfg_depth = 2'd2;
            load_start = 1'b1;
         end else begin
            load_start = 1'b0;
         end
         in_valid = 1'b1;
         in_data = words[k];
         r = in_ready;
         @(negedge clk);
         if (r) begin
            k++;
            if (gap > 0) in_valid = 1'b0;
         end
      end
      in_valid = 1'b0;
      load_start = 1'b0;
      for (int i = 0; i < 10; i++) begin
         if (!busy && addr_q.size() == 0) break;
         @(negedge clk);
      end
      chk(addr_q.size() == 0, "R2 all entries written", addr_q.size(), 0);
      chk(done_seen, "R2 done pulse", done_seen, 1);
      chk(busy == 1'b0, "R2 idle after load", busy, 0);
      if (midchg) begin
         chk(reconv_req == 1'b1, "R10 format changed during load", reconv_req, 1);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         chk(1'b0, "watchdog", cyc, 0);
         finish_up();
      end
   end

   initial begin
      cfg_fmt = 2'd2;
      repeat (3) @(negedge clk);
      chk(busy == 0 && wr_en == 0 && done == 0 && in_ready == 0, "R1 reset state",
          {busy, wr_en, done, in_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(reconv_req == 1'b0, "R10 no request before first load", reconv_req, 0);
      chk(busy == 1'b0 && wr_en == 1'b0, "R1 idle after reset", {busy, wr_en}, 0);
      mon_on = 1;

      do_load(0, 3, 0, 2, 0, "R7 format 3 decode");
      do_load(1, 0, 0, 0, 0, "R4 format 0 decode");
      chk(reconv_req == 1'b0, "R10 same format", reconv_req, 0);
      cfg_fmt = 2'd2;
      @(negedge clk);
      chk(reconv_req == 1'b1, "R10 format differs", reconv_req, 1);
      cfg_fmt = 2'd0;
      @(negedge clk);
      chk(reconv_req == 1'b0, "R10 format restored", reconv_req, 0);

      do_load(2, 1, 0, 5, 0, "R5 format 1 decode");
      do_load(1, 2, 0, 3, 0, "R6 format 2 decode");
      do_load(0, 0, 1, 0, 0, "R8 mono format 0");
      do_load(1, 3, 1, 0, 0, "R8 mono format 3");
      do_load(0, 2, 1, 2, 0, "R8 mono format 2");

      // R3: no-palette depth ignores the start
      cfg_depth = 2'd3;
      cfg_fmt = 2'd3;
      in_valid = 1'b1;
      in_data = 32'hDEAD_BEEF;
      load_start = 1'b1;
      @(negedge clk);
      load_start = 1'b0;
      for (int i = 0; i < 6; i++) begin
         chk(busy == 1'b0 && wr_en == 1'b0, "R3 start ignored", {busy, wr_en}, 0);
         @(negedge clk);
      end
      in_valid = 1'b0;
      chk(reconv_req == 1'b1, "R3 request vs kept format", reconv_req, 1);
      cfg_fmt = 2'd2;
      @(negedge clk);
      chk(reconv_req == 1'b0, "R3 remembered format unchanged", reconv_req, 0);

      do_load(1, 1, 0, 0, 1, "R12 config latched during load");
      do_load(2, 3, 0, 0, 0, "R2 full 256-entry load");

      repeat (3) @(negedge clk);
      chk(addr_q.size() == 0, "R11 no stray writes", addr_q.size(), 0);
      finish_up();
   end

endmodule